// File: doc/BRIEF.md
# Chunk-Granular Dirty Tracker with Region Flattener

This block watches writes into a set of equally sized memory banks and keeps one dirty bit for every 512-byte chunk of every bank. A linear region is built from those banks. The region is split into mapping slots, and each slot can be backed by any subset of the banks, given as a bank mask on `slotMap`. The block keeps a snapshot of the mask that each slot had at its last flatten. The reset value of every snapshot matches no real mask.

On a `start` pulse the block compares every slot's snapshot with the live mask. A slot whose mask differs is rebuilt in full. A slot whose mask is unchanged queues only those chunks whose backing bank chunks were written. The queued chunks are then copied into a flat buffer, lowest chunk first, one 64-bit word at a time.

A chunk backed by a single bank is copied directly, with one read per word. A chunk backed by several banks is rebuilt word by word from one read of each mapped bank, and the words are ORed together. A chunk backed by no bank is filled with zeros. At the end `done` pulses, and `changed` reports whether any chunk was copied. The renderer that consumes the flat buffer lies outside this block.

Top module: `dirty_flattener`

## Requirements
- R1: After reset, `busy`, `done`, `changed`, `rdEn` and `flatWe` are low, and the first flatten rebuilds every chunk of every slot, whatever the mapping.
- R2: A write with `wrEn` high and `wrBank` below NUM_BANKS marks chunk `wrAddr/512` of that bank as dirty. A write with an out-of-range bank index changes nothing. Region chunk c of slot c/SLOT_CHUNKS reads chunk (c mod BANK_CHUNKS) of each bank in the slot's mask, and a write that lands in no such chunk causes no copy.
- R3: When a slot's live mask differs from its snapshot, every chunk of that slot is copied, whether or not any of them is dirty.
- R4: Queued chunks are copied in ascending chunk order. Word w of chunk c is written at flat word address c*64+w, in ascending w.
- R5: For a chunk whose mask has exactly one bank, each word costs one read, and the flat word equals that bank's word at `rdAddr` = (c mod BANK_CHUNKS)*64+w.
- R6: For a mask with k>1 banks, each word costs k reads (one per mapped bank) and the flat word is their bitwise OR. For an empty mask, each word is written as zero with no read and takes one cycle.
- R7: `changed` is high after `done` exactly when at least one chunk was copied in that flatten. It stays at that value until the next flatten starts.
- R8: A flatten clears all bank dirty bits and records the live masks as snapshots. A second flatten with no intervening write or mask change copies nothing.
- R9: `start` while idle raises `busy` on the next cycle, and `start` while busy is ignored. `done` is a one-cycle pulse with `busy` high, after which `busy` falls. From the start edge to `done`, a flatten of n chunks takes n + 1 + the sum over those chunks of 64*max(k,1) cycles.
- R10: `rdData` is taken one cycle after `rdEn`. The flat word is written in the cycle that its last read data returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | A write lands in a bank this cycle |
| wrBank | input | 2 | Bank index of the write |
| wrAddr | input | 11 | Byte address of the write within the bank |
| slotMap | input | 12 | Live bank mask per slot, slot s in bits [s*3 +: 3] |
| start | input | 1 | Begin a flatten (taken only while idle) |
| busy | output | 1 | Flatten in progress |
| done | output | 1 | One-cycle end-of-flatten pulse |
| changed | output | 1 | At least one chunk copied in the last flatten |
| rdEn | output | 1 | Bank read request |
| rdBank | output | 2 | Bank index to read |
| rdAddr | output | 8 | 64-bit word address within the bank |
| rdData | input | 64 | Read data, valid one cycle after `rdEn` |
| flatWe | output | 1 | Flat buffer write strobe |
| flatAddr | output | 9 | Flat buffer 64-bit word address |
| flatData | output | 64 | Flat buffer write data |

## Verification
A dirty bit that is lost or a snapshot compare that is wrong shows up at the first flatten after the fault. A chunk is then missing from the flat write stream, or an extra one appears, and `changed` and the cycle count to `done` move with it. A mask or bank-select fault changes the number of `rdEn` pulses and the ORed `flatData` word of the first word of the affected chunk. An error in the order or address counters shows on the very next `flatWe`, because the flat address is checked against an ascending expected stream on every clock.

// File: rtl/dirty_flattener_pkg.sv
`timescale 1ns/1ps
package dirty_flattener_pkg;

  // index width that stays at least one bit wide
  function automatic int idxW(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_RUN  = 2'd2,
    ST_FIN  = 2'd3
  } seqState_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic capture;    // latch pending set, snapshot masks, clear dirty
    logic take;       // lowest pending chunk accepted for copying
    logic issue;      // one word step issued this cycle
    logic issueRead;  // that step carries a bank read
    logic issueLast;  // last step of the current flat word
    logic finish;     // flatten complete
  } seqStrobe_t;

endpackage

// File: rtl/lowest_set.sv
`timescale 1ns/1ps
module lowest_set #(
  parameter int N  = 8,
  parameter int IW = dirty_flattener_pkg::idxW(N)
) (
  input  logic [N-1:0]  vec,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
  assign any = |vec;
endmodule

// File: rtl/flatten_ctrl.sv
`timescale 1ns/1ps
module flatten_ctrl
  import dirty_flattener_pkg::*;
#(
  parameter int NUM_BANKS     = 3,
  parameter int REGION_CHUNKS = 8,
  parameter int CHUNK_WORDS   = 64,
  localparam int BIW = idxW(NUM_BANKS),
  localparam int CIW = idxW(REGION_CHUNKS),
  localparam int WIW = idxW(CHUNK_WORDS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic                 pendAny,
  input  logic [CIW-1:0]       pendIdx,
  input  logic [NUM_BANKS-1:0] scanMask,
  output seqStrobe_t           st,
  output logic [CIW-1:0]       chunkIdx,
  output logic [WIW-1:0]       wordIdx,
  output logic                 rdEn,
  output logic [BIW-1:0]       rdBank,
  output logic                 busy,
  output logic                 done
);
  seqState_t state;
  logic [NUM_BANKS-1:0] chunkMask;
  logic [NUM_BANKS-1:0] remain;
  logic [NUM_BANKS-1:0] remainDrop;
  logic                 remAny;
  logic [BIW-1:0]       remIdx;
  logic                 remOneLeft;
  logic                 wordEnd;

  lowest_set #(.N(NUM_BANKS), .IW(BIW)) uRemPick (
    .vec(remain), .any(remAny), .idx(remIdx)
  );

  assign remainDrop = remain - {{(NUM_BANKS-1){1'b0}}, 1'b1};
  assign remOneLeft = ((remain & remainDrop) == '0);
  assign wordEnd    = (wordIdx == WIW'(CHUNK_WORDS - 1));

  always_comb begin
    st   = '0;
    busy = (state != ST_IDLE);
    done = (state == ST_FIN);
    unique case (state)
      ST_IDLE: st.capture = start;
      ST_SCAN: st.take    = pendAny;
      ST_RUN: begin
        st.issue     = 1'b1;
        st.issueRead = remAny;
        st.issueLast = remOneLeft;
      end
      ST_FIN:  st.finish  = 1'b1;
      default: ;
    endcase
    rdEn   = st.issueRead;
    rdBank = remIdx;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      chunkIdx  <= '0;
      wordIdx   <= '0;
      chunkMask <= '0;
      remain    <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) state <= ST_SCAN;
        ST_SCAN: begin
          if (pendAny) begin
            chunkIdx  <= pendIdx;
            chunkMask <= scanMask;
            remain    <= scanMask;
            wordIdx   <= '0;
            state     <= ST_RUN;
          end else begin
            state <= ST_FIN;
          end
        end
        ST_RUN: begin
          if (remOneLeft) begin
            remain <= chunkMask;
            if (wordEnd) state <= ST_SCAN;
            else         wordIdx <= wordIdx + 1'b1;
          end else begin
            remain <= remain & remainDrop;
          end
        end
        ST_FIN:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // every read selects a bank that backs the chunk being copied
  assert_read_mapped_R6: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |-> chunkMask[rdBank]);

  // done is a single pulse followed by idle
  assert_done_then_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);

  // a start while idle is always accepted
  assert_start_taken_R9: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

endmodule

// File: rtl/flatten_datapath.sv
`timescale 1ns/1ps
module flatten_datapath
  import dirty_flattener_pkg::*;
#(
  parameter int NUM_BANKS   = 3,
  parameter int BANK_CHUNKS = 4,
  parameter int NUM_SLOTS   = 4,
  parameter int SLOT_CHUNKS = 2,
  parameter int CHUNK_BYTES = 512,
  parameter int WORD_W      = 64,
  localparam int CHUNK_WORDS   = CHUNK_BYTES / (WORD_W / 8),
  localparam int REGION_CHUNKS = NUM_SLOTS * SLOT_CHUNKS,
  localparam int BANK_ADDR_W   = $clog2(BANK_CHUNKS * CHUNK_BYTES),
  localparam int BIW = idxW(NUM_BANKS),
  localparam int BCW = idxW(BANK_CHUNKS),
  localparam int CIW = idxW(REGION_CHUNKS),
  localparam int WIW = idxW(CHUNK_WORDS),
  localparam int SNAP_W = NUM_BANKS + 1
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           wrEn,
  input  logic [BIW-1:0]                 wrBank,
  input  logic [BANK_ADDR_W-1:0]         wrAddr,
  input  logic [NUM_SLOTS*NUM_BANKS-1:0] slotMap,
  input  seqStrobe_t                     st,
  input  logic [CIW-1:0]                 chunkIdx,
  input  logic [WIW-1:0]                 wordIdx,
  input  logic [WORD_W-1:0]              rdData,
  output logic                           pendAny,
  output logic [CIW-1:0]                 pendIdx,
  output logic [NUM_BANKS-1:0]           scanMask,
  output logic                           changed,
  output logic                           flatWe,
  output logic [CIW+WIW-1:0]             flatAddr,
  output logic [WORD_W-1:0]              flatData
);
  logic [BANK_CHUNKS-1:0]   bankDirty [NUM_BANKS];
  logic [SNAP_W-1:0]        snap      [NUM_SLOTS];
  logic [NUM_BANKS-1:0]     curMap    [NUM_SLOTS];
  logic [NUM_BANKS-1:0]     dirtyCol  [BANK_CHUNKS];
  logic [NUM_BANKS-1:0]     chunkSnapMask [REGION_CHUNKS];
  logic [NUM_SLOTS-1:0]     slotStale;
  logic [REGION_CHUNKS-1:0] nextPend;
  logic [REGION_CHUNKS-1:0] pending;
  logic [BCW-1:0]           wrChunk;

  logic                     stepValid, stepRead, stepLast;
  logic [CIW+WIW-1:0]       stepAddr;
  logic [WORD_W-1:0]        acc, accNext, dataIn;

  assign wrChunk = BCW'(wrAddr / CHUNK_BYTES);

  // unpack live masks and transpose the dirty bitmap per bank chunk
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : gSlot
    assign curMap[s]    = slotMap[s*NUM_BANKS +: NUM_BANKS];
    assign slotStale[s] = (snap[s] != {1'b0, curMap[s]});
  end

  for (genvar k = 0; k < BANK_CHUNKS; k++) begin : gCol
    for (genvar b = 0; b < NUM_BANKS; b++) begin : gBit
      assign dirtyCol[k][b] = bankDirty[b][k];
    end
  end

  // region chunk c lives in slot c/SLOT_CHUNKS and reads bank chunk c mod BANK_CHUNKS
  for (genvar c = 0; c < REGION_CHUNKS; c++) begin : gChunk
    localparam int S = c / SLOT_CHUNKS;
    localparam int K = c % BANK_CHUNKS;
    assign nextPend[c]      = slotStale[S] | (|(curMap[S] & dirtyCol[K]));
    assign chunkSnapMask[c] = snap[S][NUM_BANKS-1:0];
  end

  lowest_set #(.N(REGION_CHUNKS), .IW(CIW)) uPendPick (
    .vec(pending), .any(pendAny), .idx(pendIdx)
  );

  assign scanMask = chunkSnapMask[pendIdx];

  // dirty bitmap: a write in the capture cycle survives the clear
  always_ff @(posedge clk) begin
    for (int b = 0; b < NUM_BANKS; b++) begin
      for (int k = 0; k < BANK_CHUNKS; k++) begin
        if (!rstN)
          bankDirty[b][k] <= 1'b0;
        else if (wrEn && wrBank == BIW'(b) && wrChunk == BCW'(k))
          bankDirty[b][k] <= 1'b1;
        else if (st.capture)
          bankDirty[b][k] <= 1'b0;
      end
    end
  end

  // snapshots start on a value no live mask can take
  always_ff @(posedge clk) begin
    for (int s = 0; s < NUM_SLOTS; s++) begin
      if (!rstN)           snap[s] <= {1'b1, {NUM_BANKS{1'b0}}};
      else if (st.capture) snap[s] <= {1'b0, curMap[s]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending <= '0;
      changed <= 1'b0;
    end else if (st.capture) begin
      pending <= nextPend;
      changed <= 1'b0;
    end else if (st.take) begin
      pending[pendIdx] <= 1'b0;
      changed          <= 1'b1;
    end
  end

  // read return stage: OR accumulate, write flat on the last step
  assign dataIn   = stepRead ? rdData : '0;
  assign accNext  = acc | dataIn;
  assign flatWe   = stepValid & stepLast;
  assign flatAddr = stepAddr;
  assign flatData = accNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stepValid <= 1'b0;
      stepRead  <= 1'b0;
      stepLast  <= 1'b0;
      stepAddr  <= '0;
      acc       <= '0;
    end else begin
      stepValid <= st.issue;
      stepRead  <= st.issueRead;
      stepLast  <= st.issueLast;
      stepAddr  <= {chunkIdx, wordIdx};
      if (stepValid) acc <= stepLast ? '0 : accNext;
    end
  end

  // checker state: last flat address seen in this flatten
  logic               seenFlat;
  logic [CIW+WIW-1:0] lastFlat;
  always_ff @(posedge clk) begin
    if (!rstN || st.capture) begin
      seenFlat <= 1'b0;
      lastFlat <= '0;
    end else if (flatWe) begin
      seenFlat <= 1'b1;
      lastFlat <= flatAddr;
    end
  end

  assert_flat_ascending_R4: assert property (@(posedge clk) disable iff (!rstN)
    (flatWe && seenFlat) |-> (flatAddr > lastFlat));

  assert_flat_after_last_R10: assert property (@(posedge clk) disable iff (!rstN)
    (st.issue && st.issueLast) |=> flatWe);

  assert_drained_at_end_R7: assert property (@(posedge clk) disable iff (!rstN)
    st.finish |-> (pending == '0 && !stepValid));

endmodule

// File: rtl/dirty_flattener.sv
`timescale 1ns/1ps
module dirty_flattener
  import dirty_flattener_pkg::*;
#(
  parameter int NUM_BANKS   = 3,
  parameter int BANK_CHUNKS = 4,
  parameter int NUM_SLOTS   = 4,
  parameter int SLOT_CHUNKS = 2,
  parameter int CHUNK_BYTES = 512,
  parameter int WORD_W      = 64,
  localparam int CHUNK_WORDS   = CHUNK_BYTES / (WORD_W / 8),
  localparam int REGION_CHUNKS = NUM_SLOTS * SLOT_CHUNKS,
  localparam int BANK_ADDR_W   = $clog2(BANK_CHUNKS * CHUNK_BYTES),
  localparam int BIW = idxW(NUM_BANKS),
  localparam int BCW = idxW(BANK_CHUNKS),
  localparam int CIW = idxW(REGION_CHUNKS),
  localparam int WIW = idxW(CHUNK_WORDS)
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           wrEn,
  input  logic [BIW-1:0]                 wrBank,
  input  logic [BANK_ADDR_W-1:0]         wrAddr,
  input  logic [NUM_SLOTS*NUM_BANKS-1:0] slotMap,
  input  logic                           start,
  output logic                           busy,
  output logic                           done,
  output logic                           changed,
  output logic                           rdEn,
  output logic [BIW-1:0]                 rdBank,
  output logic [BCW+WIW-1:0]             rdAddr,
  input  logic [WORD_W-1:0]              rdData,
  output logic                           flatWe,
  output logic [CIW+WIW-1:0]             flatAddr,
  output logic [WORD_W-1:0]              flatData
);
  seqStrobe_t           st;
  logic                 pendAny;
  logic [CIW-1:0]       pendIdx;
  logic [NUM_BANKS-1:0] scanMask;
  logic [CIW-1:0]       chunkIdx;
  logic [WIW-1:0]       wordIdx;

  flatten_ctrl #(
    .NUM_BANKS(NUM_BANKS), .REGION_CHUNKS(REGION_CHUNKS), .CHUNK_WORDS(CHUNK_WORDS)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .start(start),
    .pendAny(pendAny), .pendIdx(pendIdx), .scanMask(scanMask),
    .st(st), .chunkIdx(chunkIdx), .wordIdx(wordIdx),
    .rdEn(rdEn), .rdBank(rdBank), .busy(busy), .done(done)
  );

  flatten_datapath #(
    .NUM_BANKS(NUM_BANKS), .BANK_CHUNKS(BANK_CHUNKS), .NUM_SLOTS(NUM_SLOTS),
    .SLOT_CHUNKS(SLOT_CHUNKS), .CHUNK_BYTES(CHUNK_BYTES), .WORD_W(WORD_W)
  ) uData (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrBank(wrBank), .wrAddr(wrAddr),
    .slotMap(slotMap), .st(st), .chunkIdx(chunkIdx), .wordIdx(wordIdx),
    .rdData(rdData), .pendAny(pendAny), .pendIdx(pendIdx), .scanMask(scanMask),
    .changed(changed), .flatWe(flatWe), .flatAddr(flatAddr), .flatData(flatData)
  );

  // bank-local chunk is the region chunk modulo the bank size
  assign rdAddr = {BCW'(chunkIdx % BANK_CHUNKS), wordIdx};

endmodule

// File: tb/tb_dirty_flattener.sv
`timescale 1ns/1ps
module tb_dirty_flattener;
  localparam int NB = 3, BC = 4, NS = 4, SC = 2, CW = 64, RC = NS * SC;

  logic        clk = 1'b0, rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrBank = '0;
  logic [10:0] wrAddr = '0;
  logic [11:0] slotMap;
  logic        start = 1'b0;
  logic        busy, done, changed, rdEn, flatWe;
  logic [1:0]  rdBank;
  logic [7:0]  rdAddr;
  logic [63:0] rdData = '0;
  logic [8:0]  flatAddr;
  logic [63:0] flatData;

  dirty_flattener dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrBank(wrBank), .wrAddr(wrAddr),
    .slotMap(slotMap), .start(start), .busy(busy), .done(done), .changed(changed),
    .rdEn(rdEn), .rdBank(rdBank), .rdAddr(rdAddr), .rdData(rdData),
    .flatWe(flatWe), .flatAddr(flatAddr), .flatData(flatData)
  );

  always #2 clk = ~clk;

  int total = 0, bad = 0, readCnt = 0;
  logic [63:0] mem [NB][BC*CW];
  bit          mDirty [NB][BC];
  int          mSnap [NS];
  int          map [NS];
  logic [8:0]  expA [$];
  logic [63:0] expD [$];

  always_comb
    for (int s = 0; s < NS; s++) slotMap[s*NB +: NB] = map[s][NB-1:0];

  // bank memory model, one cycle read latency (R10)
  always @(posedge clk) if (rdEn) rdData <= mem[rdBank][rdAddr];

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // compare every flat write against the expected ordered stream
  always @(negedge clk) if (rstN) begin
    if (rdEn) readCnt++;
    if (flatWe) begin
      if (expA.size() == 0) check(1'b0, "R4 unexpected flat write", {55'd0, flatAddr}, 64'd0);
      else begin
        check(flatAddr == expA[0], "R4 flat address", {55'd0, flatAddr}, {55'd0, expA[0]});
        check(flatData == expD[0], "R5/R6 flat data", flatData, expD[0]);
        void'(expA.pop_front());
        void'(expD.pop_front());
      end
    end
  end

  task automatic writeWord(input int b, input int byteAddr, input logic [63:0] val);
    @(negedge clk);
    wrEn = 1'b1; wrBank = 2'(b); wrAddr = 11'(byteAddr);
    if (b < NB) begin
      mem[b][byteAddr/8] = val;
      mDirty[b][byteAddr/512] = 1'b1;
    end
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic flatten(input string tag, input bit poke);
    int n = 0, expReads = 0, expCycles = 1, cnt = 0;
    for (int c = 0; c < RC; c++) begin
      int s = c / SC, bc = c % BC, k = 0;
      bit hit = (mSnap[s] != map[s]);
      for (int b = 0; b < NB; b++)
        if (map[s][b]) begin k++; if (mDirty[b][bc]) hit = 1'b1; end
      if (hit) begin
        n++;
        expReads  += CW * k;
        expCycles += 1 + CW * ((k > 0) ? k : 1);
        for (int w = 0; w < CW; w++) begin
          logic [63:0] d = '0;
          for (int b = 0; b < NB; b++) if (map[s][b]) d |= mem[b][bc*CW + w];
          expA.push_back(9'(c*CW + w));
          expD.push_back(d);
        end
      end
    end
    for (int s = 0; s < NS; s++) mSnap[s] = map[s];
    for (int b = 0; b < NB; b++) for (int q = 0; q < BC; q++) mDirty[b][q] = 1'b0;
    readCnt = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(busy, {"R9 busy after start ", tag}, {63'd0, busy}, 64'd1);
    while (!done && cnt < 5000) begin
      start = (poke && cnt == 3);   // start while busy must be ignored (R9)
      @(negedge clk);
      cnt++;
    end
    start = 1'b0;
    check(cnt == expCycles, {"R9 cycles to done ", tag}, 64'(cnt), 64'(expCycles));
    check(changed == (n > 0), {"R7 change flag ", tag}, {63'd0, changed}, {63'd0, n > 0});
    check(readCnt == expReads, {"R5/R6 read count ", tag}, 64'(readCnt), 64'(expReads));
    check(expA.size() == 0, {"R4 writes missing ", tag}, 64'(expA.size()), 64'd0);
    expA.delete(); expD.delete();
    @(negedge clk);
    check(!busy && !done, {"R9 idle after done ", tag}, {62'd0, busy, done}, 64'd0);
  endtask

  initial begin
    #(4 * 200000);
    check(1'b0, "watchdog expired", 64'd0, 64'd1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int b = 0; b < NB; b++)
      for (int w = 0; w < BC*CW; w++)
        mem[b][w] = ({56'd0, 8'(w)} << (b*16)) | (64'h1 << (48 + b));
    for (int s = 0; s < NS; s++) mSnap[s] = -1;
    for (int b = 0; b < NB; b++) for (int q = 0; q < BC; q++) mDirty[b][q] = 1'b0;
    map[0] = 1; map[1] = 2; map[2] = 5; map[3] = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!busy,    "R1 busy",    {63'd0, busy},    64'd0);
    check(!done,    "R1 done",    {63'd0, done},    64'd0);
    check(!changed, "R1 changed", {63'd0, changed}, 64'd0);
    check(!rdEn,    "R1 rdEn",    {63'd0, rdEn},    64'd0);
    check(!flatWe,  "R1 flatWe",  {63'd0, flatWe},  64'd0);
    rstN = 1'b1;
    // R1 R3 R5 R6: all slots stale after reset; single, dual and empty masks
    flatten("full", 1'b1);
    // R8: nothing written, nothing remapped
    flatten("quiet", 1'b0);
    // R2 R4: dirty writes in descending order still copy ascending
    writeWord(1, 12'h608, 64'hDEAD_0000_BEEF_0001);
    writeWord(0, 12'h010, 64'h0123_4567_89AB_CDEF);
    flatten("dirty", 1'b0);
    // R2: chunk outside every slot's view and an out-of-range bank
    writeWord(2, 12'h400, 64'hFFFF_0000_FFFF_0000);
    writeWord(3, 12'h000, 64'h1111_1111_1111_1111);
    flatten("ignored", 1'b0);
    // R3: remapped slots rebuilt whole, one now two banks (R6)
    map[1] = 3; map[3] = 2;
    flatten("remap", 1'b0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule